// File: doc/BRIEF.md
# Hart-Side Debug Memory Window

This block is the memory-mapped target that a hart running debug code loads from and stores to. Through one word-wide access port it offers a small debug ROM, a jump word, one flag byte per hart, a two-word abstract-command buffer, a program buffer that ends in one fixed `ebreak` word, and the data words that carry command arguments. The abstract buffer lies directly below the program buffer, which lies directly below the data area. All region bases and the report addresses are parameters. The ROM image is a parameter array.

The hart reports its progress by storing to four report addresses. A store to the halted address or the resuming address carries the hart id as data. The go and exception reports act on the selected hart and on the shared error code. The command engine starts a command with a one-cycle pulse. That pulse loads the abstract buffer, raises busy and sets the go flag of the selected hart. A second pulse requests a resume of that hart. The engine clears error bits with a write-one-to-clear mask. Busy drops only when the selected hart reports halted after its go flag has already been cleared.

Top module: `dbg_hart_mem`

## Requirements
- R1: Every request is answered on the next cycle. `rsp_valid` is high for one cycle. `rsp_err` marks a rejected access, and `rdata` carries load data. `rdata` is 0 for stores and for rejected accesses.
- R2: Loads return the following:
  - the ROM words from the `ROM_WORDS` parameter at `ROM_BASE`;
  - the abstract words at `DATA_BASE - 4*(PROGBUF_N+1) - 8`, which are zero after reset;
  - the program-buffer words that follow them;
  - the fixed word 0x00100073 directly after the last program-buffer word;
  - the data words at `DATA_BASE`.
- R3: A load from `WHERETO_ADDR` returns a `jal x0` whose offset reaches the abstract-buffer base. With the default map this is 0x06C0006F.
- R4: Stores to data and program-buffer words are little-endian, and byte lane b is written only when `be[b]` is set. The fixed `ebreak` word cannot be written.
- R5: A full-word store (`be` = 4'hF) to `HALTED_ADDR` with data h < NHARTS sets `halted[h]`. If h equals `hartsel` and that hart's go flag is already clear, busy is cleared; otherwise busy keeps its value. An id of NHARTS or more is accepted and changes nothing.
- R6: A store of any width to `GOING_ADDR` clears the go flag of the selected hart.
- R7: A full-word store to `RESUMING_ADDR` with data h does three things for hart h: it clears `halted[h]`, sets `resumeack[h]` and clears the resume flag.
- R8: A store to `EXCEPTION_ADDR` sets `cmderr` to 3 only when `cmderr` is 0. Otherwise `cmderr` holds its value until `cmderr_clr` clears the bits it names.
- R9: The flag byte of hart h is at `FLAGS_BASE + h`. Bit 0 is GO and bit 1 is RESUME, and the other bits read 0. The flag bytes are load-only.
- R10: The following accesses are rejected with no change of state:
  - a misaligned address;
  - an unmapped address;
  - a store to the ROM, jump, flag or abstract regions, or to the fixed word;
  - a load from a report address;
  - a store to the halted or resuming address with `be` other than 4'hF.
- R11: A `cmd_go` pulse while not busy does three things: it loads `cmd_abs0` and `cmd_abs1` into the abstract words, sets busy and sets the go flag of `hartsel`. While busy, the pulse is ignored. A `resume_go` pulse sets the resume flag of `hartsel` and clears its `resumeack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request from the hart |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | AW | Byte address |
| be | input | 4 | Byte enables for stores |
| wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response strobe, one cycle after `req` |
| rsp_err | output | 1 | Access was rejected |
| rdata | output | 32 | Load data |
| hartsel | input | HW | Selected hart |
| cmd_go | input | 1 | Start an abstract command |
| cmd_abs0 | input | 32 | First abstract instruction |
| cmd_abs1 | input | 32 | Second abstract instruction |
| resume_go | input | 1 | Request a resume of the selected hart |
| cmderr_clr | input | 3 | Write-one-to-clear mask for `cmderr` |
| busy | output | 1 | A command is in progress |
| cmderr | output | 3 | Command error code |
| halted | output | NHARTS | Per-hart halted bits |
| resumeack | output | NHARTS | Per-hart resume-acknowledge bits |

## Verification
There are two kinds of internal fault, and each shows up within one access. A wrong go or resume flag shows in the very next load of the flag word. Busy and the halted bits are on the ports, so a wrong report decode shows on the cycle after the store. A decode fault in the address map shows as a wrong `rsp_err` or `rdata`. The sweeps over every word address with loads and with empty-enable stores catch it on the first address it touches. Sweeps over hart ids for the halted report show busy being held or released one cycle after each store.

// File: rtl/dbg_hart_mem.sv
module dbg_hart_mem #(
  parameter int AW = 12,
  parameter int NHARTS = 4,
  parameter int DATA_N = 2,
  parameter int PROGBUF_N = 2,
  parameter int ROM_N = 4,
  parameter logic [31:0] ROM_WORDS [ROM_N] = '{32'h00000013, 32'h0FF0000F, 32'h7B241073, 32'h00100073},
  parameter logic [AW-1:0] ROM_BASE = 12'h800,
  parameter logic [AW-1:0] WHERETO_ADDR = 12'h300,
  parameter logic [AW-1:0] FLAGS_BASE = 12'h400,
  parameter logic [AW-1:0] DATA_BASE = 12'h380,
  parameter logic [AW-1:0] HALTED_ADDR = 12'h100,
  parameter logic [AW-1:0] GOING_ADDR = 12'h104,
  parameter logic [AW-1:0] RESUMING_ADDR = 12'h108,
  parameter logic [AW-1:0] EXCEPTION_ADDR = 12'h10C,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rdata,
  input  logic [HW-1:0]     hartsel,
  input  logic              cmd_go,
  input  logic [31:0]       cmd_abs0,
  input  logic [31:0]       cmd_abs1,
  input  logic              resume_go,
  input  logic [2:0]        cmderr_clr,
  output logic              busy,
  output logic [2:0]        cmderr,
  output logic [NHARTS-1:0] halted,
  output logic [NHARTS-1:0] resumeack
);

  localparam logic [31:0] EBREAK_W  = 32'h00100073;
  localparam logic [31:0] DATA_B    = 32'(DATA_BASE);
  localparam logic [31:0] PB_B      = DATA_B - 32'(4 * (PROGBUF_N + 1));
  localparam logic [31:0] ABS_B     = PB_B - 32'd8;
  localparam logic [31:0] EBK_A     = PB_B + 32'(4 * PROGBUF_N);
  localparam logic [31:0] ROM_B     = 32'(ROM_BASE);
  localparam logic [31:0] WHERE_A   = 32'(WHERETO_ADDR);
  localparam logic [31:0] FLAG_B    = 32'(FLAGS_BASE);
  localparam logic [31:0] HALT_A    = 32'(HALTED_ADDR);
  localparam logic [31:0] GOING_A   = 32'(GOING_ADDR);
  localparam logic [31:0] RESUME_A  = 32'(RESUMING_ADDR);
  localparam logic [31:0] EXC_A     = 32'(EXCEPTION_ADDR);
  localparam int          FLAG_WDS  = (NHARTS + 3) / 4;
  localparam logic [31:0] JOFS      = ABS_B - WHERE_A;
  localparam logic [31:0] JAL_W     = {JOFS[20], JOFS[10:1], JOFS[11], JOFS[19:12], 5'd0, 7'h6F};

  logic [31:0]       data_q [DATA_N];
  logic [31:0]       pb_q   [PROGBUF_N];
  logic [31:0]       abs_q  [2];
  logic [NHARTS-1:0] go_q, res_q, halted_q, ack_q;
  logic              busy_q;
  logic [2:0]        cmderr_q;

  logic [31:0] a32;
  logic        ok;
  logic [31:0] rd;
  logic        exc_hit;

  assign a32 = 32'(addr);

  always_comb begin
    ok = 1'b0;
    rd = '0;
    if (addr[1:0] == 2'b00) begin
      if (!we) begin
        for (int i = 0; i < ROM_N; i++)
          if (a32 == ROM_B + 32'(4 * i)) begin ok = 1'b1; rd = ROM_WORDS[i]; end
        if (a32 == WHERE_A) begin ok = 1'b1; rd = JAL_W; end
        for (int f = 0; f < FLAG_WDS; f++)
          if (a32 == FLAG_B + 32'(4 * f)) begin
            ok = 1'b1;
            for (int b = 0; b < 4; b++)
              if (4 * f + b < NHARTS)
                rd[8*b +: 8] = {6'd0, res_q[4*f+b], go_q[4*f+b]};
          end
        for (int i = 0; i < 2; i++)
          if (a32 == ABS_B + 32'(4 * i)) begin ok = 1'b1; rd = abs_q[i]; end
        for (int i = 0; i < PROGBUF_N; i++)
          if (a32 == PB_B + 32'(4 * i)) begin ok = 1'b1; rd = pb_q[i]; end
        if (a32 == EBK_A) begin ok = 1'b1; rd = EBREAK_W; end
        for (int i = 0; i < DATA_N; i++)
          if (a32 == DATA_B + 32'(4 * i)) begin ok = 1'b1; rd = data_q[i]; end
      end else begin
        for (int i = 0; i < PROGBUF_N; i++)
          if (a32 == PB_B + 32'(4 * i)) ok = 1'b1;
        for (int i = 0; i < DATA_N; i++)
          if (a32 == DATA_B + 32'(4 * i)) ok = 1'b1;
        if (a32 == HALT_A || a32 == RESUME_A) ok = (be == 4'hF);
        if (a32 == GOING_A || a32 == EXC_A) ok = 1'b1;
      end
    end
  end

  assign exc_hit = req && we && ok && (a32 == EXC_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rdata     <= '0;
      for (int i = 0; i < DATA_N; i++) data_q[i] <= '0;
      for (int i = 0; i < PROGBUF_N; i++) pb_q[i] <= '0;
      abs_q[0]  <= '0;
      abs_q[1]  <= '0;
      go_q      <= '0;
      res_q     <= '0;
      halted_q  <= '0;
      ack_q     <= '0;
      busy_q    <= 1'b0;
      cmderr_q  <= '0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && !ok;
      rdata     <= (req && ok && !we) ? rd : '0;

      if (cmd_go && !busy_q) begin
        busy_q        <= 1'b1;
        go_q[hartsel] <= 1'b1;
        abs_q[0]      <= cmd_abs0;
        abs_q[1]      <= cmd_abs1;
      end
      if (resume_go) begin
        res_q[hartsel] <= 1'b1;
        ack_q[hartsel] <= 1'b0;
      end

      if (exc_hit && cmderr_q == 3'd0) cmderr_q <= 3'd3;
      else                             cmderr_q <= cmderr_q & ~cmderr_clr;

      if (req && we && ok) begin
        for (int i = 0; i < DATA_N; i++)
          if (a32 == DATA_B + 32'(4 * i))
            for (int b = 0; b < 4; b++)
              if (be[b]) data_q[i][8*b +: 8] <= wdata[8*b +: 8];
        for (int i = 0; i < PROGBUF_N; i++)
          if (a32 == PB_B + 32'(4 * i))
            for (int b = 0; b < 4; b++)
              if (be[b]) pb_q[i][8*b +: 8] <= wdata[8*b +: 8];
        if (a32 == HALT_A)
          for (int h = 0; h < NHARTS; h++)
            if (wdata == 32'(h)) begin
              halted_q[h] <= 1'b1;
              if (hartsel == HW'(h) && !go_q[h]) busy_q <= 1'b0;
            end
        if (a32 == GOING_A) go_q[hartsel] <= 1'b0;
        if (a32 == RESUME_A)
          for (int h = 0; h < NHARTS; h++)
            if (wdata == 32'(h)) begin
              halted_q[h] <= 1'b0;
              ack_q[h]    <= 1'b1;
              res_q[h]    <= 1'b0;
            end
      end
    end
  end

  assign busy      = busy_q;
  assign cmderr    = cmderr_q;
  assign halted    = halted_q;
  assign resumeack = ack_q;

  a_r1_err_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r10_reject_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rdata == 32'd0);
  a_r5_busy_drops_on_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(req && we && ok && a32 == HALT_A));
  a_r11_busy_rises_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_go));
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr_q != 3'd0 && cmderr_clr == 3'd0) |=> $stable(cmderr_q));

endmodule

// File: tb/test_dbg_hart_mem.sv
`timescale 1ns/1ps
module test_dbg_hart_mem;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rdata;
  logic [1:0] hartsel = '0;
  logic cmd_go = 0, resume_go = 0;
  logic [31:0] cmd_abs0 = '0, cmd_abs1 = '0;
  logic [2:0] cmderr_clr = '0;
  logic busy;
  logic [2:0] cmderr;
  logic [3:0] halted, resumeack;

  int total = 0, bad = 0;
  bit done = 0;

  dbg_hart_mem i_dbg_hart_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rdata(rdata),
    .hartsel(hartsel), .cmd_go(cmd_go), .cmd_abs0(cmd_abs0), .cmd_abs1(cmd_abs1),
    .resume_go(resume_go), .cmderr_clr(cmderr_clr), .busy(busy), .cmderr(cmderr),
    .halted(halted), .resumeack(resumeack));

  always #10 clk = ~clk;

  localparam logic [31:0] ROM_EXP [4] = '{32'h00000013, 32'h0FF0000F, 32'h7B241073, 32'h00100073};
  localparam logic [11:0] HALT_A = 12'h100, GOING_A = 12'h104, RES_A = 12'h108, EXC_A = 12'h10C;
  localparam logic [11:0] FLAG_A = 12'h400, ABS_A = 12'h36C, PB_A = 12'h374, EBK_A = 12'h37C, DAT_A = 12'h380;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit w, logic [11:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = 0; wdata = 0;
  endtask

  task automatic pulse_go(logic [31:0] x0, logic [31:0] x1);
    @(negedge clk);
    cmd_go = 1; cmd_abs0 = x0; cmd_abs1 = x1;
    @(negedge clk);
    cmd_go = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume_go = 1;
    @(negedge clk); resume_go = 0;
  endtask

  task automatic pulse_clr(logic [2:0] m);
    @(negedge clk); cmderr_clr = m;
    @(negedge clk); cmderr_clr = 0;
  endtask

  function automatic logic [32:0] exp_load(logic [11:0] a);
    if (a >= 12'h800 && a < 12'h810) return {1'b1, ROM_EXP[(a - 12'h800) >> 2]};
    if (a == 12'h300) return {1'b1, 32'h06C0006F};
    if (a == FLAG_A) return {1'b1, 32'h0};
    if (a == ABS_A || a == ABS_A + 4) return {1'b1, 32'h0};
    if (a == PB_A || a == PB_A + 4) return {1'b1, 32'h0};
    if (a == EBK_A) return {1'b1, 32'h00100073};
    if (a == DAT_A || a == DAT_A + 4) return {1'b1, 32'h0};
    return {1'b0, 32'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R11 reset busy", {31'd0, busy}, 0);
    chk("R8 reset cmderr", {29'd0, cmderr}, 0);
    chk("R5 reset halted", {28'd0, halted}, 0);
    rst_n = 1;

    for (int w = 0; w < 1024; w++) begin
      e = exp_load(12'(w * 4));
      acc(0, 12'(w * 4), 32'h0, 4'hF);
      chk($sformatf("R2 R3 R10 load err @%h", w * 4), {31'd0, rsp_err}, {31'd0, ~e[32]});
      chk($sformatf("R2 R3 load data @%h", w * 4), rdata, e[31:0]);
      chk("R1 strobe", {31'd0, rsp_valid}, 1);
    end

    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      bit okx;
      a = 12'(w * 4);
      if (a >= 12'h100 && a <= 12'h10C) continue;
      okx = (a == PB_A || a == PB_A + 4 || a == DAT_A || a == DAT_A + 4);
      acc(1, a, 32'hFFFFFFFF, 4'h0);
      chk($sformatf("R4 R9 R10 store err @%h", a), {31'd0, rsp_err}, {31'd0, ~okx});
    end

    acc(0, DAT_A + 1, 0, 4'hF);
    chk("R10 misaligned", {31'd0, rsp_err}, 1);

    acc(1, DAT_A, 32'hAABBCCDD, 4'hF);
    acc(1, DAT_A, 32'h11223344, 4'b0101);
    acc(0, DAT_A, 0, 4'hF);
    chk("R4 data byte lanes", rdata, 32'hAA22CC44);
    acc(1, PB_A + 4, 32'h99887766, 4'b1000);
    acc(0, PB_A + 4, 0, 4'hF);
    chk("R4 progbuf lane 3", rdata, 32'h99000000);
    acc(1, EBK_A, 32'h0, 4'hF);
    chk("R4 ebreak store rejected", {31'd0, rsp_err}, 1);
    acc(0, EBK_A, 0, 4'hF);
    chk("R4 ebreak kept", rdata, 32'h00100073);

    hartsel = 2;
    pulse_go(32'h12345678, 32'h00100073);
    chk("R11 busy set", {31'd0, busy}, 1);
    acc(0, FLAG_A, 0, 4'hF);
    chk("R9 R11 go flag hart2", rdata, 32'h00010000);
    pulse_go(32'hDEADBEEF, 32'h0);
    acc(0, ABS_A, 0, 4'hF);
    chk("R11 abs0 kept while busy", rdata, 32'h12345678);
    acc(0, ABS_A + 4, 0, 4'hF);
    chk("R11 abs1", rdata, 32'h00100073);
    acc(1, FLAG_A, 32'h0, 4'hF);
    chk("R9 flags store rejected", {31'd0, rsp_err}, 1);
    acc(0, FLAG_A, 0, 4'hF);
    chk("R9 flags unchanged", rdata, 32'h00010000);

    acc(1, HALT_A, 32'd2, 4'hF);
    chk("R5 halted[2] set", {28'd0, halted}, 32'h4);
    chk("R5 busy kept, go set", {31'd0, busy}, 1);
    acc(1, GOING_A, 32'h0, 4'h1);
    acc(0, FLAG_A, 0, 4'hF);
    chk("R6 go cleared", rdata, 32'h0);

    acc(1, HALT_A, 32'd1, 4'h3);
    chk("R10 short halted store", {31'd0, rsp_err}, 1);
    chk("R10 halted unchanged", {28'd0, halted}, 32'h4);
    acc(1, HALT_A, 32'd7, 4'hF);
    chk("R5 id out of range", {28'd0, halted}, 32'h4);
    chk("R5 busy after bad id", {31'd0, busy}, 1);
    for (int h = 0; h < 4; h++) begin
      if (h == 2) continue;
      acc(1, HALT_A, 32'(h), 4'hF);
      chk($sformatf("R5 busy held id %0d", h), {31'd0, busy}, 1);
    end
    chk("R5 all halted", {28'd0, halted}, 32'hF);
    acc(1, HALT_A, 32'd2, 4'hF);
    chk("R5 busy cleared by selected hart", {31'd0, busy}, 0);

    pulse_resume();
    chk("R11 resumeack cleared", {28'd0, resumeack}, 0);
    acc(0, FLAG_A, 0, 4'hF);
    chk("R9 R11 resume flag hart2", rdata, 32'h00020000);
    acc(1, RES_A, 32'd2, 4'hF);
    chk("R7 halted[2] cleared", {28'd0, halted}, 32'hB);
    chk("R7 resumeack[2]", {28'd0, resumeack}, 32'h4);
    acc(0, FLAG_A, 0, 4'hF);
    chk("R7 resume flag cleared", rdata, 32'h0);
    acc(1, RES_A, 32'd0, 4'hE);
    chk("R10 short resuming", {28'd0, halted}, 32'hB);

    acc(1, EXC_A, 32'h0, 4'hF);
    chk("R8 exception sets 3", {29'd0, cmderr}, 3);
    pulse_clr(3'b001);
    chk("R8 w1c", {29'd0, cmderr}, 2);
    acc(1, EXC_A, 32'h0, 4'hF);
    chk("R8 sticky nonzero", {29'd0, cmderr}, 2);
    pulse_clr(3'b111);
    chk("R8 cleared", {29'd0, cmderr}, 0);
    acc(0, EXC_A, 0, 4'hF);
    chk("R10 load from report addr", {31'd0, rsp_err}, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule